// File: doc/BRIEF.md
# UART Register Bank Page Decoder

This block holds the configuration registers of a single 16550-style UART channel with an enhanced-feature extension. It sits between a simple synchronous register bus and the serializers, which are not part of it. The value held in the line-control register decides what a small set of low addresses means: in the normal page they report FIFO fill levels and accept FIFO control writes, with the divisor-access bit set they reach the two baud divisor bytes, and a single key value written to the line-control register opens a hidden page in which the enhanced-feature register appears. Writing any other line-control value closes that page again.

Besides decoding, the block produces the FIFO control strobes (single-cycle clear pulses, FIFO enable) and the receive trigger level, either from a two-bit selector or from an override register reachable only when enhanced functions are unlocked. It also performs hardware flow control: RTS follows the modem-control RTS bit and, with automatic RTS on, drops while the receive FIFO holds more than the trigger level; with automatic CTS on, the transmit-enable output follows a synchronized copy of CTS so the transmitter starts no new character while CTS is low.

The register bus is a plain single-cycle interface with no back-pressure: every write is taken on the clock edge where `bus_wr` is high, and read data is registered and valid from the cycle after `bus_rd`, holding until the next read.

Top module: `uart_regbank`

## Requirements
- R1: After reset the line-control, modem-control, feature, divisor, scratch and trigger registers are zero, the FIFO control readback is zero, `rts_out`, `fifo_enable`, `rx_flush` and `tx_flush` are low and `tx_allow` is high.
- R2: While line-control bit 7 is set, address 0 reads and writes the divisor low byte and address 1 the divisor high byte, with `divisor` = {high, low}; while bit 7 is clear, address 0 reads `rx_level`, address 1 reads `tx_level`, and writes to them leave `divisor` unchanged.
- R3: While the line-control register holds 0xBF, address 2 reads and writes the feature register; at any other line-control value a write to address 2 goes to FIFO control and the feature register keeps its value. Addresses 0 and 1 reach the divisor in the 0xBF page too.
- R4: Writing any line-control value other than 0xBF closes the feature page; a later value with bit 7 clear restores the level readback at addresses 0 and 1.
- R5: While feature bit 4 (enhanced enable) is set, writes to the divisor bytes are ignored, so the divisor must be programmed before that bit is set.
- R6: A FIFO control write (address 2, feature page closed) with bit 1 set raises `rx_flush`, and with bit 2 set raises `tx_flush`, for exactly the one cycle after the write edge; bit 0 sets `fifo_enable`; readback at address 2 returns bits 7:6 and bit 0 with the clear bits reading zero.
- R7: FIFO control bits 7:6 select the receive trigger level as 00: depth/8, 01: depth/4, 10: depth-8, 11: depth-4 (8, 16, 56, 60 at depth 64).
- R8: Modem-control bits 2 (trigger access) and 6 (infrared mode, driving `irda_mode`) change on a write only while feature bit 4 is set; the other modem-control bits are always writable. Modem-control is at address 4.
- R9: With feature bit 4 and modem-control bit 2 both set, address 6 reads and writes the trigger register, whose nonzero upper nibble N sets the receive trigger to 4*N (capped at depth); otherwise address 6 reads zero and ignores writes.
- R10: With feature bit 6 (automatic RTS) set, `rts_out` is high one cycle after modem-control bit 1 is set and `rx_level` is at or below the trigger, and low one cycle after `rx_level` exceeds it or bit 1 is cleared; with feature bit 6 clear, `rts_out` follows modem-control bit 1 one cycle later.
- R11: With feature bit 7 (automatic CTS) set, `tx_allow` follows `cts_in` after `CTS_SYNC` clock edges; with it clear, `tx_allow` is high.
- R12: `bus_rdata` changes only on the edge after a cycle with `bus_rd` high and otherwise holds its value. Address 5 is a scratch byte; address 3 reads back the line-control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| rx_level | input | LVLW | Receive FIFO fill level |
| tx_level | input | LVLW | Transmit FIFO fill level |
| cts_in | input | 1 | Clear-to-send from the line, high = asserted |
| rts_out | output | 1 | Request-to-send to the line, high = asserted |
| tx_allow | output | 1 | Transmitter may start a new character |
| rx_flush | output | 1 | One-cycle receive FIFO clear |
| tx_flush | output | 1 | One-cycle transmit FIFO clear |
| fifo_enable | output | 1 | FIFOs enabled |
| divisor | output | 16 | Baud divisor |
| line_ctrl | output | 7 | Line-control bits 6:0 for the serializers |
| irda_mode | output | 1 | Infrared encoding selected |

## Verification
The bench builds the block with its defaults: a 64-entry FIFO, a two-stage CTS synchronizer and 0xBF as the page key. At depth 64 all four selector triggers (8, 16, 56, 60) and an override of 12 are reachable with level inputs one step on either side, so each threshold edge of automatic RTS is exercised. Two synchronizer stages make the CTS latency long enough to tell one edge of delay from two.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;

  typedef enum logic [1:0] {
    PG_NORMAL   = 2'd0,
    PG_DIVISOR  = 2'd1,
    PG_ENHANCED = 2'd2
  } page_e;

  localparam logic [2:0] ADR_LO      = 3'd0;
  localparam logic [2:0] ADR_HI      = 3'd1;
  localparam logic [2:0] ADR_FIFO    = 3'd2;
  localparam logic [2:0] ADR_LINE    = 3'd3;
  localparam logic [2:0] ADR_MODEM   = 3'd4;
  localparam logic [2:0] ADR_SCRATCH = 3'd5;
  localparam logic [2:0] ADR_TRIG    = 3'd6;

  localparam int LCR_DIV_BIT  = 7;
  localparam int EFR_ENH_BIT  = 4;
  localparam int EFR_ARTS_BIT = 6;
  localparam int EFR_ACTS_BIT = 7;
  localparam int MCR_RTS_BIT  = 1;
  localparam int MCR_TRIG_BIT = 2;
  localparam int MCR_IRDA_BIT = 6;
  localparam int FCR_EN_BIT   = 0;
  localparam int FCR_RXC_BIT  = 1;
  localparam int FCR_TXC_BIT  = 2;

  // modem-control bits that only change while enhanced functions are on
  localparam logic [7:0] MCR_GUARDED = 8'h44;

  typedef struct packed {
    logic div_lo;
    logic div_hi;
    logic feat;
    logic fifo;
    logic line;
    logic modem;
    logic scratch;
    logic trig;
  } wsel_t;

endpackage

// File: rtl/rb_page_decode.sv
module rb_page_decode
  import uart_regbank_pkg::*;
#(
  parameter logic [7:0] KEY = 8'hBF
) (
  input  logic       wr,
  input  logic [2:0] addr,
  input  logic [7:0] lcr,
  input  logic       enh,
  input  logic       trig_acc,
  output page_e      page,
  output wsel_t      wsel,
  output logic       trig_open
);

  always_comb begin
    if (lcr == KEY)            page = PG_ENHANCED;
    else if (lcr[LCR_DIV_BIT]) page = PG_DIVISOR;
    else                       page = PG_NORMAL;
  end

  assign trig_open = enh & trig_acc;

  always_comb begin
    wsel = '0;
    if (wr) begin
      unique case (addr)
        ADR_LO:      wsel.div_lo  = (page != PG_NORMAL) && !enh;
        ADR_HI:      wsel.div_hi  = (page != PG_NORMAL) && !enh;
        ADR_FIFO: begin
          wsel.feat = (page == PG_ENHANCED);
          wsel.fifo = (page != PG_ENHANCED);
        end
        ADR_LINE:    wsel.line    = 1'b1;
        ADR_MODEM:   wsel.modem   = 1'b1;
        ADR_SCRATCH: wsel.scratch = 1'b1;
        ADR_TRIG:    wsel.trig    = trig_open;
        default:     wsel         = '0;
      endcase
    end
  end

endmodule

// File: rtl/rb_fifo_ctrl.sv
module rb_fifo_ctrl #(
  parameter int DEPTH = 64,
  parameter int LVLW  = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_fifo,
  input  logic [1:0]      trig_sel,
  input  logic            en_bit,
  input  logic            rxc_bit,
  input  logic            txc_bit,
  input  logic [3:0]      ovr_nib,
  output logic [7:0]      fcr_view,
  output logic            fifo_en,
  output logic            rx_flush,
  output logic            tx_flush,
  output logic [LVLW-1:0] rx_trig
);

  localparam int TRIG_Q1 = DEPTH / 8;
  localparam int TRIG_Q2 = DEPTH / 4;
  localparam int TRIG_Q3 = DEPTH - 8;
  localparam int TRIG_Q4 = DEPTH - 4;

  logic [1:0] sel_q;
  logic       en_q;
  logic       rxf_q;
  logic       txf_q;
  int         trig_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      en_q  <= 1'b0;
      rxf_q <= 1'b0;
      txf_q <= 1'b0;
    end else begin
      rxf_q <= wr_fifo & rxc_bit;
      txf_q <= wr_fifo & txc_bit;
      if (wr_fifo) begin
        sel_q <= trig_sel;
        en_q  <= en_bit;
      end
    end
  end

  always_comb begin
    if (ovr_nib != 4'd0) begin
      trig_i = 4 * int'(ovr_nib);
    end else begin
      unique case (sel_q)
        2'd0:    trig_i = TRIG_Q1;
        2'd1:    trig_i = TRIG_Q2;
        2'd2:    trig_i = TRIG_Q3;
        default: trig_i = TRIG_Q4;
      endcase
    end
    if (trig_i > DEPTH) trig_i = DEPTH;
  end

  assign rx_trig  = LVLW'(trig_i);
  assign fcr_view = {sel_q, 5'b0, en_q};
  assign fifo_en  = en_q;
  assign rx_flush = rxf_q;
  assign tx_flush = txf_q;

endmodule

// File: rtl/rb_flow_ctrl.sv
module rb_flow_ctrl #(
  parameter int LVLW = 7,
  parameter int SYNC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mcr_rts,
  input  logic            auto_rts,
  input  logic            auto_cts,
  input  logic [LVLW-1:0] rx_level,
  input  logic [LVLW-1:0] rx_trig,
  input  logic            cts_in,
  output logic            rts_out,
  output logic            tx_allow
);

  logic [SYNC-1:0] cts_sr;
  logic            rts_q;

  generate
    if (SYNC == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cts_sr <= '0;
        else        cts_sr <= cts_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cts_sr <= '0;
        else        cts_sr <= {cts_sr[SYNC-2:0], cts_in};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rts_q <= 1'b0;
    else        rts_q <= mcr_rts & (!auto_rts | (rx_level <= rx_trig));
  end

  assign rts_out  = rts_q;
  assign tx_allow = !auto_cts | cts_sr[SYNC-1];

endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_regbank_pkg::*;
#(
  parameter int          FIFO_DEPTH = 64,
  parameter int          CTS_SYNC   = 2,
  parameter logic [7:0]  PAGE_KEY   = 8'hBF,
  localparam int         LVLW       = $clog2(FIFO_DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [2:0]      bus_addr,
  input  logic [7:0]      bus_wdata,
  output logic [7:0]      bus_rdata,
  input  logic [LVLW-1:0] rx_level,
  input  logic [LVLW-1:0] tx_level,
  input  logic            cts_in,
  output logic            rts_out,
  output logic            tx_allow,
  output logic            rx_flush,
  output logic            tx_flush,
  output logic            fifo_enable,
  output logic [15:0]     divisor,
  output logic [6:0]      line_ctrl,
  output logic            irda_mode
);

  logic [7:0] lcr_q, dll_q, dlm_q, efr_q, mcr_q, spr_q, tlr_q;
  logic [7:0] fcr_view;
  logic [7:0] rd_next;
  logic [7:0] rdata_q;
  logic [LVLW-1:0] rx_trig;
  page_e      page;
  wsel_t      wsel;
  logic       trig_open;
  logic       enh;

  assign enh = efr_q[EFR_ENH_BIT];

  rb_page_decode #(.KEY(PAGE_KEY)) u_dec (
    .wr        (bus_wr),
    .addr      (bus_addr),
    .lcr       (lcr_q),
    .enh       (enh),
    .trig_acc  (mcr_q[MCR_TRIG_BIT]),
    .page      (page),
    .wsel      (wsel),
    .trig_open (trig_open)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr_q <= '0;
      dll_q <= '0;
      dlm_q <= '0;
      efr_q <= '0;
      mcr_q <= '0;
      spr_q <= '0;
      tlr_q <= '0;
    end else begin
      if (wsel.line)    lcr_q <= bus_wdata;
      if (wsel.div_lo)  dll_q <= bus_wdata;
      if (wsel.div_hi)  dlm_q <= bus_wdata;
      if (wsel.feat)    efr_q <= bus_wdata;
      if (wsel.scratch) spr_q <= bus_wdata;
      if (wsel.trig)    tlr_q <= bus_wdata;
      if (wsel.modem)
        mcr_q <= (bus_wdata & ~MCR_GUARDED) |
                 ((enh ? bus_wdata : mcr_q) & MCR_GUARDED);
    end
  end

  rb_fifo_ctrl #(.DEPTH(FIFO_DEPTH), .LVLW(LVLW)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_fifo  (wsel.fifo),
    .trig_sel (bus_wdata[7:6]),
    .en_bit   (bus_wdata[FCR_EN_BIT]),
    .rxc_bit  (bus_wdata[FCR_RXC_BIT]),
    .txc_bit  (bus_wdata[FCR_TXC_BIT]),
    .ovr_nib  (tlr_q[7:4]),
    .fcr_view (fcr_view),
    .fifo_en  (fifo_enable),
    .rx_flush (rx_flush),
    .tx_flush (tx_flush),
    .rx_trig  (rx_trig)
  );

  rb_flow_ctrl #(.LVLW(LVLW), .SYNC(CTS_SYNC)) u_flow (
    .clk      (clk),
    .rst_n    (rst_n),
    .mcr_rts  (mcr_q[MCR_RTS_BIT]),
    .auto_rts (efr_q[EFR_ARTS_BIT]),
    .auto_cts (efr_q[EFR_ACTS_BIT]),
    .rx_level (rx_level),
    .rx_trig  (rx_trig),
    .cts_in   (cts_in),
    .rts_out  (rts_out),
    .tx_allow (tx_allow)
  );

  always_comb begin
    unique case (bus_addr)
      ADR_LO:      rd_next = (page != PG_NORMAL) ? dll_q : 8'(rx_level);
      ADR_HI:      rd_next = (page != PG_NORMAL) ? dlm_q : 8'(tx_level);
      ADR_FIFO:    rd_next = (page == PG_ENHANCED) ? efr_q : fcr_view;
      ADR_LINE:    rd_next = lcr_q;
      ADR_MODEM:   rd_next = mcr_q;
      ADR_SCRATCH: rd_next = spr_q;
      ADR_TRIG:    rd_next = trig_open ? tlr_q : 8'h00;
      default:     rd_next = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_next;
  end

  assign bus_rdata = rdata_q;
  assign divisor   = {dlm_q, dll_q};
  assign line_ctrl = lcr_q[6:0];
  assign irda_mode = mcr_q[MCR_IRDA_BIT];

endmodule

// File: rtl/rb_chk.sv
module rb_chk
  import uart_regbank_pkg::*;
#(
  parameter int         LVLW = 7,
  parameter logic [7:0] KEY  = 8'hBF
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_wr,
  input logic            bus_rd,
  input logic [2:0]      bus_addr,
  input logic [7:0]      bus_rdata,
  input logic [7:0]      lcr_q,
  input logic [7:0]      efr_q,
  input logic            mcr_rts,
  input logic [15:0]     divisor,
  input logic            rts_out,
  input logic            tx_allow,
  input logic            rx_flush,
  input logic [LVLW-1:0] rx_level,
  input logic [LVLW-1:0] rx_trig
);

  // R5
  div_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(efr_q[EFR_ENH_BIT]) |-> $stable(divisor));

  // R3
  feat_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_wr && bus_addr == ADR_FIFO && lcr_q != KEY) |-> $stable(efr_q));

  // R10
  rts_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(efr_q[EFR_ARTS_BIT]) |-> (rts_out == $past(mcr_rts)));

  // R10
  rts_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(efr_q[EFR_ARTS_BIT] && (rx_level > rx_trig)) |-> !rts_out);

  // R11
  cts_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !efr_q[EFR_ACTS_BIT] |-> tx_allow);

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd) |-> $stable(bus_rdata));

  // R6
  flush_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |-> $past(bus_wr));

endmodule

bind uart_regbank rb_chk #(.LVLW(LVLW), .KEY(PAGE_KEY)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .lcr_q     (lcr_q),
  .efr_q     (efr_q),
  .mcr_rts   (mcr_q[1]),
  .divisor   (divisor),
  .rts_out   (rts_out),
  .tx_allow  (tx_allow),
  .rx_flush  (rx_flush),
  .rx_level  (rx_level),
  .rx_trig   (rx_trig)
);

// File: tb/uart_regbank_test.sv
module uart_regbank_test;

  localparam int LVLW = 7;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_wr = 1'b0;
  logic            bus_rd = 1'b0;
  logic [2:0]      bus_addr = '0;
  logic [7:0]      bus_wdata = '0;
  logic [7:0]      bus_rdata;
  logic [LVLW-1:0] rx_level = '0;
  logic [LVLW-1:0] tx_level = '0;
  logic            cts_in = 1'b1;
  logic            rts_out, tx_allow, rx_flush, tx_flush, fifo_enable, irda_mode;
  logic [15:0]     divisor;
  logic [6:0]      line_ctrl;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  uart_regbank uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_level(rx_level), .tx_level(tx_level), .cts_in(cts_in),
    .rts_out(rts_out), .tx_allow(tx_allow), .rx_flush(rx_flush),
    .tx_flush(tx_flush), .fifo_enable(fifo_enable), .divisor(divisor),
    .line_ctrl(line_ctrl), .irda_mode(irda_mode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_feat(input logic [7:0] v);
    wr(3'd3, 8'hBF);
    wr(3'd2, v);
    wr(3'd3, 8'h03);
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 rts", rts_out, 0);
    chk("R1 tx_allow", tx_allow, 1);
    chk("R1 fifo_enable", fifo_enable, 0);
    chk("R1 flush", {rx_flush, tx_flush}, 0);
    chk("R1 divisor", divisor, 0);
    rd(3'd3, d); chk("R1 line", d, 8'h00);
    rd(3'd4, d); chk("R1 modem", d, 8'h00);
    rd(3'd2, d); chk("R1 fifo view", d, 8'h00);
    rd(3'd5, d); chk("R1 scratch", d, 8'h00);
  endtask

  task automatic t_divisor_page();
    logic [7:0] d;
    rx_level = 7'd5; tx_level = 7'd9;
    rd(3'd0, d); chk("R2 rx level read", d, 8'd5);
    rd(3'd1, d); chk("R2 tx level read", d, 8'd9);
    wr(3'd0, 8'h55);
    chk("R2 normal write no divisor", divisor, 16'h0000);
    wr(3'd3, 8'h83);
    wr(3'd0, 8'h34);
    wr(3'd1, 8'h12);
    chk("R2 divisor value", divisor, 16'h1234);
    rd(3'd0, d); chk("R2 low byte read", d, 8'h34);
    rd(3'd1, d); chk("R2 high byte read", d, 8'h12);
    chk("R2 line_ctrl", line_ctrl, 7'h03);
  endtask

  task automatic t_page_close();
    logic [7:0] d;
    wr(3'd3, 8'h03);
    rd(3'd0, d); chk("R4 normal map restored", d, 8'd5);
    rd(3'd3, d); chk("R4 line readback", d, 8'h03);
  endtask

  task automatic t_feat_page();
    logic [7:0] d;
    wr(3'd3, 8'hBF);
    wr(3'd2, 8'hC0);
    rd(3'd2, d); chk("R3 feature readback", d, 8'hC0);
    rd(3'd0, d); chk("R3 divisor in key page", d, 8'h34);
    chk("R3 fifo untouched", fifo_enable, 0);
    wr(3'd3, 8'h83);
    rd(3'd2, d); chk("R4 page closed by other value", d, 8'h00);
    wr(3'd2, 8'h01);
    chk("R3 write went to fifo ctrl", fifo_enable, 1);
    wr(3'd3, 8'hBF);
    rd(3'd2, d); chk("R3 feature kept", d, 8'hC0);
    wr(3'd3, 8'h03);
  endtask

  task automatic t_div_lock();
    set_feat(8'h10);
    wr(3'd3, 8'h83);
    wr(3'd0, 8'hAA);
    chk("R5 divisor locked", divisor, 16'h1234);
    wr(3'd3, 8'h03);
    set_feat(8'h00);
    wr(3'd3, 8'h83);
    wr(3'd0, 8'hAA);
    chk("R5 divisor unlocked", divisor, 16'h12AA);
    wr(3'd3, 8'h03);
  endtask

  task automatic t_modem_guard();
    logic [7:0] d;
    wr(3'd4, 8'h46);
    rd(3'd4, d); chk("R8 guarded bits held", d, 8'h02);
    chk("R8 irda off", irda_mode, 0);
    set_feat(8'h10);
    wr(3'd4, 8'h46);
    rd(3'd4, d); chk("R8 guarded bits written", d, 8'h46);
    chk("R8 irda on", irda_mode, 1);
  endtask

  task automatic t_trig_reg();
    logic [7:0] d;
    wr(3'd4, 8'h06);
    wr(3'd6, 8'h30);
    rd(3'd6, d); chk("R9 trigger reg readback", d, 8'h30);
    wr(3'd4, 8'h02);
    rd(3'd6, d); chk("R9 closed reads zero", d, 8'h00);
    wr(3'd6, 8'h50);
    wr(3'd4, 8'h06);
    rd(3'd6, d); chk("R9 closed write ignored", d, 8'h30);
  endtask

  task automatic t_flush();
    logic [7:0] d;
    wr(3'd2, 8'h03);
    chk("R6 rx flush pulse", {rx_flush, tx_flush}, 2'b10);
    chk("R6 fifo enable", fifo_enable, 1);
    settle();
    chk("R6 rx flush ends", {rx_flush, tx_flush}, 2'b00);
    wr(3'd2, 8'h05);
    chk("R6 tx flush pulse", {rx_flush, tx_flush}, 2'b01);
    settle();
    chk("R6 tx flush ends", tx_flush, 0);
    rd(3'd2, d); chk("R6 clear bits read zero", d, 8'h01);
  endtask

  task automatic lvl_pair(input string req, input int trig);
    rx_level = 7'(trig); settle(); settle();
    chk(req, rts_out, 1);
    rx_level = 7'(trig + 1); settle(); settle();
    chk(req, rts_out, 0);
  endtask

  task automatic t_auto_rts();
    set_feat(8'h50);
    settle();
    lvl_pair("R9 override trigger 12", 12);
    rx_level = 7'd12; settle();
    settle(); chk("R10 reassert at trigger", rts_out, 1);
    wr(3'd6, 8'h00);
    wr(3'd2, 8'h41); lvl_pair("R7 trigger 16", 16);
    wr(3'd2, 8'h81); lvl_pair("R7 trigger 56", 56);
    wr(3'd2, 8'hC1); lvl_pair("R7 trigger 60", 60);
    wr(3'd2, 8'h01); lvl_pair("R7 trigger 8", 8);
    rx_level = 7'd0;
    wr(3'd4, 8'h04);
    settle(); chk("R10 rts follows modem bit low", rts_out, 0);
    set_feat(8'h10);
    rx_level = 7'd64;
    wr(3'd4, 8'h06);
    chk("R10 one cycle lag", rts_out, 0);
    settle(); chk("R10 plain rts ignores level", rts_out, 1);
  endtask

  task automatic t_auto_cts();
    set_feat(8'h90);
    chk("R11 cts high passes", tx_allow, 1);
    @(negedge clk); cts_in = 1'b0;
    settle(); chk("R11 one edge not yet", tx_allow, 1);
    settle(); chk("R11 two edges blocked", tx_allow, 0);
    cts_in = 1'b1;
    settle(); settle(); chk("R11 released", tx_allow, 1);
    cts_in = 1'b0;
    set_feat(8'h10);
    chk("R11 auto off forces allow", tx_allow, 1);
    cts_in = 1'b1;
  endtask

  task automatic t_read_hold();
    logic [7:0] d;
    wr(3'd5, 8'h5A);
    rd(3'd5, d); chk("R12 scratch read", d, 8'h5A);
    wr(3'd5, 8'hA5);
    settle();
    chk("R12 rdata held", bus_rdata, 8'h5A);
    rd(3'd5, d); chk("R12 new read", d, 8'hA5);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    t_reset();
    t_divisor_page();
    t_page_close();
    t_feat_page();
    t_div_lock();
    t_modem_guard();
    t_trig_reg();
    t_flush();
    t_auto_rts();
    t_auto_cts();
    t_read_hold();
    finish_run();
  end

endmodule